// File: doc/BRIEF.md
# Windowed Pixel Write Address Generator

This block turns a stream of pixel write strobes into addresses for a frame memory of 168 rows by 128 columns by 9 bits. A host first sets up a rectangular write window with four bound registers: column start, column end, row start and row end. It then sends pixel strobes. For each strobe the block puts out one registered memory address with a write-enable pulse, and then moves its internal column/row pointers on to the next location inside the window.

The scan order can be set. In row-first order the column pointer advances first. In column-first order the row pointer advances first. In both orders the pointers return to the window origin after the last cell of the window. Two mirror flags reflect the issued column and/or row address about the far edge of the array. Mirroring acts only on the issued address; the scan pointers are not changed. Writing any bound register sends the pointers back to the window origin. Colour expansion of the pixel byte, the memory array and the command decoding all sit outside this block.

Top module: `pixwin_addr_gen`

## Requirements
- R1: After reset, `ram_we` is 0, the window covers the whole array (columns 0..127, rows 0..167), row-first order and both mirror flags are off, and the first pixel strobe goes to column 0, row 0.
- R2: A register write (`cfg_we`=1) with `cfg_sel` 0 sets column start, 1 sets column end, 2 sets row start, 3 sets row end, and 4 sets the scan mode from `cfg_wdata` bit 0 (1 = column-first), bit 1 (mirror column) and bit 2 (mirror row). Selects 5 to 7 have no effect.
- R3: Each cycle with `pix_valid`=1 gives exactly one cycle of `ram_we`=1 on the next clock edge, with that pixel's address on `ram_x`/`ram_y`. Back-to-back strobes are accepted every cycle with no stall. `ram_we` is 0 in every other cycle.
- R4: In row-first order the column pointer goes up by one per pixel. A pixel at the column end moves the column pointer back to the column start and the row pointer up by one.
- R5: In column-first order the row pointer goes up by one per pixel. A pixel at the row end moves the row pointer back to the row start and the column pointer up by one.
- R6: After the pixel at both the column end and the row end, the next pixel goes to (column start, row start), in either order.
- R7: With mirror column set, `ram_x` = 127 − column pointer. With mirror row set, `ram_y` = 167 − row pointer. The mirror flags do not change the pointers.
- R8: Writing any of the four bound registers sends both pointers to the window origin (using the newly written value). Writing the mode register leaves the pointers where they are.
- R9: A column bound above 127 is stored as 127, and a row bound above 167 is stored as 167.
- R10: If a pixel strobe and a register write fall in the same cycle, the pixel is issued at the pointer and mode in force before the write. For a bound write, the pointers then go to the new origin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (see R2) |
| cfg_wdata | input | 8 | Register write value |
| pix_valid | input | 1 | Pixel strobe, one pixel per high cycle |
| ram_we | output | 1 | Frame memory write enable, one cycle per pixel |
| ram_x | output | 7 | Frame memory column address |
| ram_y | output | 8 | Frame memory row address |

## Verification
The hardest case to reach from the ports is the wrap at the very last cell of the full-size array, because it only happens after 21,504 pixels. The bench sets the full window in column-first order and streams 21,505 back-to-back pixels, checking every address including the final wrap to the origin. The second hard case is a bound write and a pixel strobe landing on the same edge. Both are driven on the same falling edge, so their relative order is fixed.

// File: rtl/pixwin_pkg.sv
// Package: shared types for the windowed pixel address generator.
// Assumes: the register select field is 3 bits wide.
package pixwin_pkg;

    // Register select codes on cfg_sel
    typedef enum logic [2:0] {
        SEL_X_START = 3'd0,
        SEL_X_END   = 3'd1,
        SEL_Y_START = 3'd2,
        SEL_Y_END   = 3'd3,
        SEL_MODE    = 3'd4
    } cfg_sel_e;

    // Scan mode word; vert is bit 0, mirror_x bit 1, mirror_y bit 2
    typedef struct packed {
        logic mirror_y;
        logic mirror_x;
        logic vert;
    } scan_mode_t;

endpackage

// File: rtl/pixwin_cfg_regs.sv
// Module: window bound and scan mode registers.
// Stores the four window bounds, clamping each to the array limit, and the
// scan mode word. It also gives a reload request and the origin that the
// pointers must take on this edge, so a bound write is seen at once.
// Assumes: DATA_W is at least XW and YW; the host keeps start <= end.
module pixwin_cfg_regs
    import pixwin_pkg::*;
#(
    parameter int XW     = 7,
    parameter int YW     = 8,
    parameter int DATA_W = 8,
    parameter int X_MAX  = 127,
    parameter int Y_MAX  = 167
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [XW-1:0]     win_xs,
    output logic [XW-1:0]     win_xe,
    output logic [YW-1:0]     win_ys,
    output logic [YW-1:0]     win_ye,
    output scan_mode_t        mode,
    output logic              reload,
    output logic [XW-1:0]     org_x_nxt,
    output logic [YW-1:0]     org_y_nxt
);

    localparam logic [DATA_W-1:0] X_LIM = DATA_W'(X_MAX);
    localparam logic [DATA_W-1:0] Y_LIM = DATA_W'(Y_MAX);
    localparam logic [XW-1:0]     X_TOP = XW'(X_MAX);
    localparam logic [YW-1:0]     Y_TOP = YW'(Y_MAX);

    logic [XW-1:0] x_val;
    logic [YW-1:0] y_val;
    logic          wr_xs, wr_xe, wr_ys, wr_ye, wr_mode;

    // Clamp the incoming value to each axis limit
    always_comb begin
        x_val = (cfg_wdata > X_LIM) ? X_TOP : cfg_wdata[XW-1:0];
        y_val = (cfg_wdata > Y_LIM) ? Y_TOP : cfg_wdata[YW-1:0];
    end

    // Decode the select into one write strobe per register
    always_comb begin
        wr_xs   = cfg_we && (cfg_sel == SEL_X_START);
        wr_xe   = cfg_we && (cfg_sel == SEL_X_END);
        wr_ys   = cfg_we && (cfg_sel == SEL_Y_START);
        wr_ye   = cfg_we && (cfg_sel == SEL_Y_END);
        wr_mode = cfg_we && (cfg_sel == SEL_MODE);
    end

    // Reload request and the origin in force after this edge
    always_comb begin
        reload    = wr_xs || wr_xe || wr_ys || wr_ye;
        org_x_nxt = wr_xs ? x_val : win_xs;
        org_y_nxt = wr_ys ? y_val : win_ys;
    end

    // Bound and mode storage; reset opens the window to the whole array
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_xs <= '0;
            win_xe <= X_TOP;
            win_ys <= '0;
            win_ye <= Y_TOP;
            mode   <= '0;
        end else begin
            if (wr_xs)   win_xs <= x_val;
            if (wr_xe)   win_xe <= x_val;
            if (wr_ys)   win_ys <= y_val;
            if (wr_ye)   win_ye <= y_val;
            if (wr_mode) mode   <= scan_mode_t'(cfg_wdata[2:0]);
        end
    end

endmodule

// File: rtl/pixwin_axis.sv
// Module: one scan pointer axis.
// Counts from the window start to the window end and wraps back to the
// start on a step taken at the end. A reload overrides any step.
// Assumes: start <= stop while stepping.
module pixwin_axis #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         reload,
    input  logic [W-1:0] start,
    input  logic [W-1:0] stop,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] ptr,
    output logic         at_stop
);

    // Flag the last position of the window on this axis
    always_comb at_stop = (ptr == stop);

    // Pointer register: reload, wrap or increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (reload) begin
            ptr <= reload_val;
        end else if (step) begin
            ptr <= at_stop ? start : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/pixwin_mirror.sv
// Module: optional reflection of one axis address about the array edge.
// When the array size is a power of two the reflection is a bit inversion,
// otherwise a subtraction from the top address.
// Assumes: ptr never exceeds MAX.
module pixwin_mirror #(
    parameter int W   = 7,
    parameter int MAX = 127
) (
    input  logic [W-1:0] ptr,
    input  logic         flip,
    output logic [W-1:0] addr
);

    localparam logic [W-1:0] TOP = W'(MAX);

    generate
        if (MAX == (1 << W) - 1) begin : g_invert
            // Full binary range: reflect by inverting the bits
            always_comb addr = flip ? ~ptr : ptr;
        end else begin : g_subtract
            // Partial range: reflect by subtracting from the top
            always_comb addr = flip ? TOP - ptr : ptr;
        end
    endgenerate

endmodule

// File: rtl/pixwin_addr_gen.sv
// Module: windowed pixel write address generator (top).
// Issues one registered frame memory address with a write pulse for each
// pixel strobe, then advances the column/row pointers inside the window
// in the selected order. Mirroring acts on the issued address only.
// Assumes: the host keeps start <= end on both axes.
module pixwin_addr_gen
    import pixwin_pkg::*;
#(
    parameter int X_COUNT = 128,
    parameter int Y_COUNT = 168,
    parameter int DATA_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [2:0]                   cfg_sel,
    input  logic [DATA_W-1:0]            cfg_wdata,
    input  logic                         pix_valid,
    output logic                         ram_we,
    output logic [$clog2(X_COUNT)-1:0]   ram_x,
    output logic [$clog2(Y_COUNT)-1:0]   ram_y
);

    localparam int XW    = $clog2(X_COUNT);
    localparam int YW    = $clog2(Y_COUNT);
    localparam int X_MAX = X_COUNT - 1;
    localparam int Y_MAX = Y_COUNT - 1;

    logic [XW-1:0] win_xs, win_xe, org_x_nxt, ptr_x, mir_x;
    logic [YW-1:0] win_ys, win_ye, org_y_nxt, ptr_y, mir_y;
    scan_mode_t    mode;
    logic          reload;
    logic          x_at_stop, y_at_stop;
    logic          x_step, y_step;

    pixwin_cfg_regs #(
        .XW(XW), .YW(YW), .DATA_W(DATA_W), .X_MAX(X_MAX), .Y_MAX(Y_MAX)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .win_xs    (win_xs),
        .win_xe    (win_xe),
        .win_ys    (win_ys),
        .win_ye    (win_ye),
        .mode      (mode),
        .reload    (reload),
        .org_x_nxt (org_x_nxt),
        .org_y_nxt (org_y_nxt)
    );

    // Step enables: the fast axis steps every pixel, the slow axis on its wrap
    always_comb begin
        if (mode.vert) begin
            y_step = pix_valid;
            x_step = pix_valid && y_at_stop;
        end else begin
            x_step = pix_valid;
            y_step = pix_valid && x_at_stop;
        end
    end

    pixwin_axis #(.W(XW)) u_axis_x (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (x_step),
        .reload     (reload),
        .start      (win_xs),
        .stop       (win_xe),
        .reload_val (org_x_nxt),
        .ptr        (ptr_x),
        .at_stop    (x_at_stop)
    );

    pixwin_axis #(.W(YW)) u_axis_y (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (y_step),
        .reload     (reload),
        .start      (win_ys),
        .stop       (win_ye),
        .reload_val (org_y_nxt),
        .ptr        (ptr_y),
        .at_stop    (y_at_stop)
    );

    pixwin_mirror #(.W(XW), .MAX(X_MAX)) u_mir_x (
        .ptr  (ptr_x),
        .flip (mode.mirror_x),
        .addr (mir_x)
    );

    pixwin_mirror #(.W(YW), .MAX(Y_MAX)) u_mir_y (
        .ptr  (ptr_y),
        .flip (mode.mirror_y),
        .addr (mir_y)
    );

    // Output register: one write pulse and address per accepted pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we <= 1'b0;
            ram_x  <= '0;
            ram_y  <= '0;
        end else begin
            ram_we <= pix_valid;
            if (pix_valid) begin
                ram_x <= mir_x;
                ram_y <= mir_y;
            end
        end
    end

endmodule

// File: rtl/pixwin_addr_gen_chk.sv
// Module: assertion checker for the windowed address generator, bound to
// the top. Watches the ports and the pointer and bound state over time.
// Assumes: the host keeps start <= end on both axes.
module pixwin_addr_gen_chk
    import pixwin_pkg::*;
#(
    parameter int XW    = 7,
    parameter int YW    = 8,
    parameter int Y_MAX = 167
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [2:0]    cfg_sel,
    input logic          pix_valid,
    input logic          ram_we,
    input logic [YW-1:0] ram_y,
    input logic [XW-1:0] ptr_x,
    input logic [YW-1:0] ptr_y,
    input logic [XW-1:0] win_xs,
    input logic [XW-1:0] win_xe,
    input logic [YW-1:0] win_ys,
    input logic [YW-1:0] win_ye,
    input scan_mode_t    mode
);

    localparam logic [YW-1:0] Y_TOP = YW'(Y_MAX);

    assert_we_follows_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> ram_we);

    assert_no_spurious_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !ram_we);

    assert_row_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_y <= Y_TOP));

    assert_bound_clamped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_ye <= Y_TOP) && (win_ys <= Y_TOP));

    assert_horiz_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !cfg_we && !mode.vert && (ptr_x != win_xe))
        |=> (ptr_x == $past(ptr_x) + 1'b1) && $stable(ptr_y));

    assert_vert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !cfg_we && mode.vert && (ptr_y != win_ye))
        |=> (ptr_y == $past(ptr_y) + 1'b1) && $stable(ptr_x));

    assert_window_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !cfg_we && (ptr_x == win_xe) && (ptr_y == win_ye))
        |=> (ptr_x == win_xs) && (ptr_y == win_ys));

    assert_reload_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_sel <= 3'd3)) |=> (ptr_x == win_xs) && (ptr_y == win_ys));

    assert_mode_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_sel == 3'd4) && !pix_valid) |=> $stable(ptr_x) && $stable(ptr_y));

endmodule

bind pixwin_addr_gen pixwin_addr_gen_chk #(
    .XW(XW), .YW(YW), .Y_MAX(Y_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .pix_valid (pix_valid),
    .ram_we    (ram_we),
    .ram_y     (ram_y),
    .ptr_x     (ptr_x),
    .ptr_y     (ptr_y),
    .win_xs    (win_xs),
    .win_xe    (win_xe),
    .win_ys    (win_ys),
    .win_ye    (win_ye),
    .mode      (mode)
);

// File: tb/pixwin_addr_gen_test.sv
`timescale 1ns/1ps
// Directed bench for the windowed address generator. Each scenario is a
// task that drives on the falling edge and checks its own results there.
module pixwin_addr_gen_test;

    localparam real HALF = 2.5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic       pix_valid = 1'b0;
    logic       ram_we;
    logic [6:0] ram_x;
    logic [7:0] ram_y;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Bench model of the programmed state, built from the requirements
    int m_xs, m_xe, m_ys, m_ye, m_px, m_py;
    bit m_v, m_mx, m_my;

    always #(HALF) clk = ~clk;

    pixwin_addr_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .pix_valid (pix_valid),
        .ram_we    (ram_we),
        .ram_x     (ram_x),
        .ram_y     (ram_y)
    );

    function automatic int exp_x();
        return m_mx ? 127 - m_px : m_px;
    endfunction

    function automatic int exp_y();
        return m_my ? 167 - m_py : m_py;
    endfunction

    task automatic model_reset();
        m_xs = 0; m_xe = 127; m_ys = 0; m_ye = 167;
        m_px = 0; m_py = 0; m_v = 0; m_mx = 0; m_my = 0;
    endtask

    task automatic model_step();
        if (m_v) begin
            if (m_py == m_ye) begin
                m_py = m_ys;
                m_px = (m_px == m_xe) ? m_xs : m_px + 1;
            end else m_py++;
        end else begin
            if (m_px == m_xe) begin
                m_px = m_xs;
                m_py = (m_py == m_ye) ? m_ys : m_py + 1;
            end else m_px++;
        end
    endtask

    task automatic model_cfg(int sel, int d);
        case (sel)
            0: m_xs = (d > 127) ? 127 : d;
            1: m_xe = (d > 127) ? 127 : d;
            2: m_ys = (d > 167) ? 167 : d;
            3: m_ye = (d > 167) ? 167 : d;
            4: begin m_v = d[0]; m_mx = d[1]; m_my = d[2]; end
            default: ;
        endcase
        if (sel < 4) begin m_px = m_xs; m_py = m_ys; end
    endtask

    task automatic check_addr(string req, int ex, int ey);
        n_checks++;
        if (ram_we !== 1'b1 || int'(ram_x) != ex || int'(ram_y) != ey) begin
            n_fail++;
            $display("FAIL %s: we=%0b x=%0d y=%0d, expected we=1 x=%0d y=%0d",
                     req, ram_we, ram_x, ram_y, ex, ey);
        end
    endtask

    task automatic check_idle(string req);
        n_checks++;
        if (ram_we !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: we=%0b, expected we=0", req, ram_we);
        end
    endtask

    task automatic cfg_write(int sel, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel[2:0]; cfg_wdata = d[7:0];
        @(negedge clk);
        cfg_we = 1'b0;
        model_cfg(sel, d);
    endtask

    task automatic set_window(int xs, int xe, int ys, int ye);
        cfg_write(1, xe); cfg_write(3, ye); cfg_write(0, xs); cfg_write(2, ys);
    endtask

    // Stream n back-to-back pixels and check each issued address
    task automatic push(int n, string req);
        int ex, ey;
        @(negedge clk);
        pix_valid = 1'b1;
        ex = exp_x(); ey = exp_y(); model_step();
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            check_addr(req, ex, ey);
            ex = exp_x(); ey = exp_y(); model_step();
        end
        @(negedge clk);
        pix_valid = 1'b0;
        check_addr(req, ex, ey);
        @(negedge clk);
        check_idle("R3");
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");
        n_checks++;
        if (ram_x !== 7'd0 || ram_y !== 8'd0) begin
            n_fail++;
            $display("FAIL R1: x=%0d y=%0d, expected x=0 y=0", ram_x, ram_y);
        end
        push(3, "R1");
    endtask

    task automatic t_horizontal();
        set_window(2, 4, 5, 6);
        push(7, "R4/R6 row-first window");
    endtask

    task automatic t_vertical();
        cfg_write(4, 1);
        set_window(10, 11, 20, 22);
        push(7, "R5/R6 column-first window");
    endtask

    task automatic t_mirror();
        cfg_write(4, 0);
        set_window(0, 3, 0, 2);
        cfg_write(4, 6);
        push(3, "R7 mirror both");
        cfg_write(4, 0);
        push(2, "R7/R8 mirror off, pointers kept");
        cfg_write(4, 7);
        push(4, "R7 mirror column-first");
    endtask

    task automatic t_clamp();
        cfg_write(4, 0);
        cfg_write(1, 200);
        cfg_write(3, 255);
        cfg_write(0, 126);
        cfg_write(2, 166);
        push(5, "R9 clamped bounds");
        cfg_write(0, 250);
        cfg_write(2, 250);
        push(2, "R9 start clamped");
    endtask

    task automatic t_reload();
        set_window(5, 9, 3, 4);
        push(3, "R8 pre-reload");
        cfg_write(1, 9);
        push(2, "R8 reload on bound write");
        cfg_write(5, 99);
        cfg_write(7, 1);
        push(2, "R2 ignored selects");
    endtask

    task automatic t_same_cycle();
        int ex, ey;
        set_window(1, 6, 1, 6);
        push(2, "R10 setup");
        ex = exp_x(); ey = exp_y();
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 8'd4; pix_valid = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; pix_valid = 1'b0;
        check_addr("R10 pixel at old pointer", ex, ey);
        model_cfg(0, 4);
        push(2, "R10 new origin after write");
    endtask

    task automatic t_full_array();
        cfg_write(4, 1);
        set_window(0, 127, 0, 167);
        push(168 * 128 + 1, "R6 full array wrap");
    endtask

    initial begin
        t_reset();
        t_horizontal();
        t_vertical();
        t_mirror();
        t_clamp();
        t_reload();
        t_same_cycle();
        t_full_array();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule